// File: doc/BRIEF.md
# Double-Buffered Pixel Array Driver

This block controls a matrix of pixel cells, each of which switches one on/off output. Each cell holds two stored bits, one per bank. One bank feeds the outputs during an exposure while the next frame is loaded into the other bank. A row of pixel data arrives as one wide parallel word. A capture strobe copies it into a column line register. A write strobe then copies that register into one addressed row of the bank chosen by a bank select input.

An exposure enable input does not reach all rows at once. It steps through a chain of flops, one clock per row, so row 0 switches first and each later row switches one clock after the row before it. This spreads the switching current over time. Turning the enable off steps through the rows in the same order. A pixel output is high only while its row enable is high and the cell's bit in the displayed bank is 1. The displayed bank is fixed when the exposure enable rises and stays fixed until the next rise.

Top module: `pixarray_drv`

## Requirements
- R1: `cap_stb` high at a clock edge copies `row_data` into the column line register. With `cap_stb` low, the register holds its value even when `row_data` changes.
- R2: `wr_stb` high at a clock edge copies the column line register into row `row_addr` of the bank chosen by `bank_sel`. No other row is changed and the other bank is not changed. A write happens only on edges where `wr_stb` is high.
- R3: When `cap_stb` and `wr_stb` are high in the same cycle, the row receives the line value from before that capture, and the new word is captured for later use.
- R4: `bank_sel` = 0 targets bank A and `bank_sel` = 1 targets bank B. A write to the bank that is not displayed never changes `pix_out`.
- R5: On the edge where `exp_en` is sampled high while `row_en[0]` is low, the displayed bank is set to the complement of `bank_sel`. Changes to `bank_sel` while the exposure stays on do not change the displayed bank.
- R6: `row_en[0]` goes high (or low) one clock after `exp_en` is sampled high (or low). `row_en[k]` follows `row_en[k-1]` by one clock.
- R7: `pix_out[r*NUM_COLS + c]` equals `row_en[r]` AND the bit at column c of row r in the displayed bank.
- R8: `wipe` high while `wr_stb` is low clears both banks of every row, the column line register and the row enable chain at that edge.
- R9: When `wipe` and `wr_stb` are high together, the write is performed and nothing is cleared.
- R10: `rst_n` low at a clock edge clears both banks, the line register and the enable chain, and selects bank A for display. After reset, `pix_out` and `row_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_data | input | NUM_COLS | Parallel word for one row of pixels |
| cap_stb | input | 1 | Captures `row_data` into the column line register |
| wr_stb | input | 1 | Writes the line register into the addressed row |
| wipe | input | 1 | Clears all storage and the enable chain when `wr_stb` is low |
| bank_sel | input | 1 | Write target bank (0 = A, 1 = B); its complement is the displayed bank at exposure start |
| row_addr | input | ROW_W | Row targeted by a write |
| exp_en | input | 1 | Exposure enable fed into the row delay chain |
| row_enable | output | NUM_ROWS | Delayed enable of each row |
| pix_out | output | NUM_ROWS*NUM_COLS | Pixel drive bits, row-major |

## Verification
The bench goes after these corner cases:
- A capture and a write in the same cycle. A design that wrote the fresh word would show the new pattern in that row.
- Writes to the hidden bank during an exposure. A design that decoded the bank wrongly would disturb the displayed pixels.
- Toggling the bank select while the exposure is on. A design that followed the select live would swap frames mid-exposure.
- The rising and falling ripple of the enable. The bench checks each row's step, so a chain with a missing or extra stage, or one that switches every row together, gives the wrong mask.
- A wipe that coincides with a write. A design that let the wipe win would lose the written row.

// File: rtl/pixarray_pkg.sv
// Shared types for the pixel array driver.
// Assumes: bank A is encoded as 0 and bank B as 1, matching the write select.
package pixarray_pkg;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    // Bank shown during an exposure: the one not being written.
    function automatic bank_e shown_for_write(input logic wr_bank);
        return wr_bank ? BANK_A : BANK_B;
    endfunction

endpackage

// File: rtl/pixarray_line_latch.sv
// Column line register: holds one row word between capture and write.
// Assumes: clr is already qualified (wipe without a write) by the parent.
module pixarray_line_latch #(
    parameter int NUM_COLS = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                cap_stb,
    input  logic [NUM_COLS-1:0] row_data,
    output logic [NUM_COLS-1:0] line_q
);

    // Capture the incoming word on the strobe; clear on reset or wipe.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            line_q <= '0;
        end else if (cap_stb) begin
            line_q <= row_data;
        end
    end

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_stb && !clr) |=> $stable(line_q));   // R1
    AST_LINE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (line_q == '0));                    // R8

endmodule

// File: rtl/pixarray_cells.sv
// Two-bank cell storage: one bit per pixel per bank, written one row at a time.
// The displayed bank's contents are presented as a row-by-column matrix.
// Assumes: row_addr values at or beyond NUM_ROWS write nothing.
module pixarray_cells
    import pixarray_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int NUM_COLS = 100,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               clr,
    input  logic                               wr_stb,
    input  logic                               bank_sel,
    input  logic [ROW_W-1:0]                   row_addr,
    input  logic [NUM_COLS-1:0]                line_q,
    input  bank_e                              disp_bank,
    output logic [NUM_ROWS-1:0][NUM_COLS-1:0]  shown
);

    logic [NUM_ROWS-1:0][NUM_COLS-1:0] bank_a;
    logic [NUM_ROWS-1:0][NUM_COLS-1:0] bank_b;

    // Write the line word into the addressed row of the selected bank.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bank_a <= '0;
            bank_b <= '0;
        end else if (wr_stb) begin
            for (int r = 0; r < NUM_ROWS; r++) begin
                if (int'(row_addr) == r) begin
                    if (bank_sel) begin
                        bank_b[r] <= line_q;
                    end else begin
                        bank_a[r] <= line_q;
                    end
                end
            end
        end
    end

    // Route the displayed bank to the output gating.
    always_comb begin
        shown = (disp_bank == BANK_B) ? bank_b : bank_a;
    end

    AST_B_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !bank_sel) |=> $stable(bank_b));   // R4
    AST_A_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && bank_sel) |=> $stable(bank_a));    // R4
    AST_WIPE_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bank_a == '0 && bank_b == '0));       // R8

endmodule

// File: rtl/pixarray_oe_chain.sv
// Staggered exposure enable: one flop per row, so row k turns on k+1
// clocks after the enable is sampled. Also fixes the displayed bank at
// each exposure start.
// Assumes: an exposure starts when exp_en is high while row 0 is still off.
module pixarray_oe_chain
    import pixarray_pkg::*;
#(
    parameter int NUM_ROWS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                exp_en,
    input  logic                bank_sel,
    output logic [NUM_ROWS-1:0] row_en,
    output bank_e               disp_bank
);

    logic start_exp;

    // Detect the first enabled cycle of an exposure.
    always_comb begin
        start_exp = exp_en && !row_en[0];
    end

    // Shift the enable down the rows, one clock per row.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row_en <= '0;
        end else begin
            row_en[0] <= exp_en;
            for (int k = 1; k < NUM_ROWS; k++) begin
                row_en[k] <= row_en[k-1];
            end
        end
    end

    // Fix the displayed bank at exposure start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_bank <= BANK_A;
        end else if (!clr && start_exp) begin
            disp_bank <= shown_for_write(bank_sel);
        end
    end

    AST_DISP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_en && row_en[0] && !clr) |=> $stable(disp_bank));   // R5
    AST_ROW0_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_en[0]) |-> $past(exp_en));                     // R6

    for (genvar k = 1; k < NUM_ROWS; k++) begin : g_ripple_chk
        AST_RIPPLE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(row_en[k]) |-> $past(row_en[k-1]));            // R6
    end

endmodule

// File: rtl/pixarray_drv.sv
// Top of the double-buffered pixel array driver: line register, two-bank
// cells, staggered enable chain and per-pixel output gating.
// Assumes: pix_out is row-major, bit r*NUM_COLS+c is row r, column c.
module pixarray_drv
    import pixarray_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int NUM_COLS = 100,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int NUM_PIX = NUM_ROWS * NUM_COLS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COLS-1:0] row_data,
    input  logic                cap_stb,
    input  logic                wr_stb,
    input  logic                wipe,
    input  logic                bank_sel,
    input  logic [ROW_W-1:0]    row_addr,
    input  logic                exp_en,
    output logic [NUM_ROWS-1:0] row_enable,
    output logic [NUM_PIX-1:0]  pix_out
);

    logic                              clr;
    logic [NUM_COLS-1:0]               line_q;
    logic [NUM_ROWS-1:0][NUM_COLS-1:0] shown;
    bank_e                             disp_bank;

    // A wipe only acts in cycles without a write.
    always_comb begin
        clr = wipe && !wr_stb;
    end

    pixarray_line_latch #(
        .NUM_COLS (NUM_COLS)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .cap_stb  (cap_stb),
        .row_data (row_data),
        .line_q   (line_q)
    );

    pixarray_cells #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_COLS (NUM_COLS)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_stb    (wr_stb),
        .bank_sel  (bank_sel),
        .row_addr  (row_addr),
        .line_q    (line_q),
        .disp_bank (disp_bank),
        .shown     (shown)
    );

    pixarray_oe_chain #(
        .NUM_ROWS (NUM_ROWS)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .exp_en    (exp_en),
        .bank_sel  (bank_sel),
        .row_en    (row_enable),
        .disp_bank (disp_bank)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row_gate
        // Gate one row of pixels with that row's delayed enable.
        always_comb begin
            pix_out[r*NUM_COLS +: NUM_COLS] = row_enable[r] ? shown[r] : '0;
        end

        AST_DARK_ROW: assert property (@(posedge clk) disable iff (!rst_n)
            !row_enable[r] |-> (pix_out[r*NUM_COLS +: NUM_COLS] == '0));   // R7
    end

    AST_WIPE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (row_enable == '0));   // R8

endmodule

// File: tb/pixarray_drv_bench.sv
`timescale 1ns/1ps
module pixarray_drv_bench;
    localparam int NR = 8;
    localparam int NC = 100;
    localparam int AW = 3;
    localparam int NP = NR * NC;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, cap, wr, wipe, sel, oe;
    logic [AW-1:0] addr;
    logic [NC-1:0] din;
    logic [NR-1:0] ren;
    logic [NP-1:0] pix;

    pixarray_drv #(.NUM_ROWS(NR), .NUM_COLS(NC)) u_pixarray_drv (
        .clk(clk), .rst_n(rst_n), .row_data(din), .cap_stb(cap), .wr_stb(wr),
        .wipe(wipe), .bank_sel(sel), .row_addr(addr), .exp_en(oe),
        .row_enable(ren), .pix_out(pix)
    );

    // Reference state built from the requirements.
    logic [NR-1:0][NC-1:0] m_a, m_b;
    logic [NC-1:0]         m_line;
    logic                  m_disp;
    logic [NR-1:0]         m_chain;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done   = 1'b0;
    logic [NP-1:0] snap;

    always @(posedge clk) begin
        if (!rst_n || (wipe && !wr)) begin
            m_a <= '0; m_b <= '0; m_line <= '0; m_chain <= '0;
            if (!rst_n) m_disp <= 1'b0;
        end else begin
            if (cap) m_line <= din;
            if (wr) begin
                if (sel) m_b[addr] <= m_line;
                else     m_a[addr] <= m_line;
            end
            if (oe && !m_chain[0]) m_disp <= !sel;
            m_chain <= {m_chain[NR-2:0], oe};
        end
    end

    function automatic logic [NP-1:0] exp_pix();
        logic [NP-1:0] v;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                v[r*NC+c] = m_chain[r] & (m_disp ? m_b[r][c] : m_a[r][c]);
        return v;
    endfunction

    function automatic logic [NC-1:0] rnd_row();
        logic [127:0] t;
        t = {$urandom, $urandom, $urandom, $urandom};
        return t[NC-1:0];
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_row(input int r, input logic b, input logic [NC-1:0] d);
        din = d; cap = 1'b1; tick(1);
        cap = 1'b0; din = rnd_row(); addr = AW'(r); sel = b; wr = 1'b1; tick(1);
        wr = 1'b0;
    endtask

    task automatic expose(input logic bank);
        oe = 1'b0; tick(NR + 1);
        sel = !bank; oe = 1'b1; tick(NR + 1);
    endtask

    // Cycle-by-cycle comparison against the reference state.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk(ren == m_chain, "R6", NP'(ren), NP'(m_chain));
            chk(pix == exp_pix(), "R7", pix, exp_pix());
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; cap = 1'b0; wr = 1'b0; wipe = 1'b0; sel = 1'b0; oe = 1'b0;
        addr = '0; din = '0;
        tick(3);
        chk_on = 1'b1;
        chk(ren == '0 && pix == '0, "R10", pix, '0);
        rst_n = 1'b1;

        // R1/R2: fill bank A; row_data changes after each capture.
        for (int r = 0; r < NR; r++) load_row(r, 1'b0, rnd_row());
        // R3: capture and write in one cycle stores the older line.
        din = rnd_row(); cap = 1'b1; tick(1);
        din = rnd_row(); cap = 1'b1; wr = 1'b1; addr = 3'd2; sel = 1'b0; tick(1);
        cap = 1'b0; wr = 1'b0;

        // R6: rising ripple, row by row.
        sel = 1'b1; oe = 1'b1;
        for (int k = 1; k <= NR; k++) begin
            tick(1);
            chk(ren == NR'((1 << k) - 1), "R6", NP'(ren), NP'((1 << k) - 1));
        end
        chk(pix == exp_pix(), "R1", pix, exp_pix());
        chk(pix == exp_pix(), "R2", pix, exp_pix());
        chk(pix == exp_pix(), "R3", pix, exp_pix());
        snap = pix;

        // R4: load the hidden bank during the exposure.
        for (int r = 0; r < NR; r++) begin
            load_row(r, 1'b1, rnd_row());
            chk(pix == snap, "R4", pix, snap);
        end
        // R5: select toggles without a new exposure start.
        sel = 1'b0; tick(3); sel = 1'b1; tick(2); sel = 1'b0; tick(1);
        chk(pix == snap, "R5", pix, snap);

        // R6: falling ripple.
        oe = 1'b0;
        for (int k = 1; k <= NR; k++) begin
            tick(1);
            chk(ren == NR'(~((1 << k) - 1)), "R6", NP'(ren), NP'(NR'(~((1 << k) - 1))));
        end

        // R5: new exposure shows bank B.
        sel = 1'b0; oe = 1'b1; tick(NR + 1);
        chk(pix == exp_pix() && pix != snap, "R5", pix, exp_pix());

        // R9: wipe together with a write keeps everything and writes.
        oe = 1'b0; din = rnd_row(); cap = 1'b1; tick(1);
        cap = 1'b0; wipe = 1'b1; wr = 1'b1; sel = 1'b1; addr = 3'd5; tick(1);
        wipe = 1'b0; wr = 1'b0;
        expose(1'b1);
        chk(pix == exp_pix() && pix != '0, "R9", pix, exp_pix());

        // R8: wipe alone clears banks, line and chain.
        wipe = 1'b1; tick(1); wipe = 1'b0; oe = 1'b0;
        chk(ren == '0, "R8", NP'(ren), '0);
        wr = 1'b1; sel = 1'b0; addr = 3'd1; tick(1); wr = 1'b0;
        expose(1'b0);
        chk(pix == '0, "R8", pix, '0);
        expose(1'b1);
        chk(pix == '0, "R8", pix, '0);

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            cap  = ($urandom % 3) == 0;
            wr   = ($urandom % 4) == 0;
            wipe = ($urandom % 60) == 0;
            sel  = $urandom % 2;
            addr = AW'($urandom % NR);
            din  = rnd_row();
            if (($urandom % 20) == 0) oe = !oe;
            tick(1);
        end

        // R10: reset during an exposure.
        cap = 1'b0; wr = 1'b0; wipe = 1'b0; oe = 1'b1;
        for (int r = 0; r < NR; r++) load_row(r, 1'b1, rnd_row());
        rst_n = 1'b0; tick(1); rst_n = 1'b1; oe = 1'b0;
        chk(ren == '0 && pix == '0, "R10", pix, '0);
        tick(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule